// File: doc/BRIEF.md
# Command Submission Queue with Puller

This block takes programmed-I/O writes that a host makes into a user command window and turns each one into a queued command entry. The write address is split into a channel number, a subchannel number and a method offset, and these are stored with the write data. Two caches hold entries. A one-entry slot takes commands that software injects on a separate port. A deeper FIFO takes the bus writes, and it holds the host off with a wait signal while it is full.

A puller takes one entry per cycle from the caches, and the injected slot goes first. An entry whose channel differs from the active channel is not taken. The puller raises a context-switch request naming the wanted channel and stalls until the request is acknowledged, and the acknowledge makes that channel active. An entry that is taken is checked against the subchannel binding mask and the method limit. A good entry is issued downstream. A bad entry is diverted to the runout path with a reason code, and a saturating runout counter records it.

Top module: `cmd_fifo_puller`

## Requirements
- R1: A write address of 19 bits decodes as channel = addr[18:16], subchannel = addr[15:13] (an 8 KB window each) and method offset = addr[12:0]. These fields appear unchanged on out_chan, out_subch and out_method.
- R2: After reset the active channel is 0, ctx_req, out_valid, ro_valid, wr_wait and sw_busy are low, and ro_count is 0.
- R3: The bus FIFO keeps the order of writes and holds DEPTH entries. wr_wait is high while it holds DEPTH entries. A write made while wr_wait is high is dropped.
- R4: The injection slot holds exactly one entry, and sw_busy is high while that entry is held. An injection made while sw_busy is high is dropped.
- R5: When both caches hold an entry, the puller takes the injection slot's entry first.
- R6: A bus write accepted at one clock edge whose entry is valid and on the active channel is shown on out_valid (a one-cycle pulse) after the next edge. The puller takes at most one entry per cycle.
- R7: An entry whose subchannel bit in obj_bound is 0 is not issued. It pulses ro_valid instead, and out_reason bit 0 is set.
- R8: An entry whose method offset is METHOD_LIMIT or above is not issued. It pulses ro_valid instead, and out_reason bit 1 is set.
- R9: ro_count goes up by one for each diverted entry and stops at RO_DEPTH. ro_full is high exactly when ro_count equals RO_DEPTH.
- R10: When the head entry's channel is not the active channel, ctx_req rises with ctx_chan set to that channel, and no entry is taken while ctx_req is high. ctx_ack makes ctx_chan the active channel and clears ctx_req.
- R11: ctx_ack has no effect while ctx_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe into the user window |
| wr_addr | input | 19 | Host write address |
| wr_data | input | 32 | Host write data |
| wr_wait | output | 1 | Bus FIFO full; the write is not taken |
| sw_en | input | 1 | Software injection strobe |
| sw_addr | input | 19 | Injected command address |
| sw_data | input | 32 | Injected command data |
| sw_busy | output | 1 | Injection slot occupied |
| obj_bound | input | 8 | One bit per subchannel: an object is bound |
| ctx_ack | input | 1 | Context switch acknowledge |
| ctx_req | output | 1 | Context switch request |
| ctx_chan | output | 3 | Channel the request asks for |
| active_chan | output | 3 | Channel currently active |
| out_valid | output | 1 | A valid entry is issued downstream |
| ro_valid | output | 1 | An entry is diverted to runout |
| out_chan | output | 3 | Channel of the entry |
| out_subch | output | 3 | Subchannel of the entry |
| out_method | output | 13 | Method offset of the entry |
| out_data | output | 32 | Data of the entry |
| out_reason | output | 2 | Diversion reason: bit 0 unbound, bit 1 method out of range |
| ro_count | output | 3 | Saturating count of diverted entries |
| ro_full | output | 1 | Runout count at its limit |

## Verification
The assertions take for granted that ctx_ack is only meaningful while a request is pending, and that the host may strobe writes at any time, including while wr_wait or sw_busy is high. The stimulus drives every input at the falling edge and holds it for exactly one rising edge. It acknowledges a switch only once ctx_req is seen high. It makes writes during wait and busy on purpose so that the drop rules are exercised. obj_bound is held constant through the run, which gives a fixed mix of bound and unbound subchannels, and the expected routing of each entry is worked out from that mask.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int CH_W = 3;
  localparam int SC_W = 3;
  localparam int MT_W = 13;
  localparam int DW   = 32;
  localparam int AW   = CH_W + SC_W + MT_W;
  localparam int NSUB = 1 << SC_W;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic [SC_W-1:0] subch;
    logic [MT_W-1:0] method;
    logic [DW-1:0]   data;
  } cmd_t;

  function automatic cmd_t split_addr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_t c;
    c.chan   = a[AW-1 -: CH_W];
    c.subch  = a[MT_W +: SC_W];
    c.method = a[MT_W-1:0];
    c.data   = d;
    return c;
  endfunction
endpackage

// File: rtl/cfp_sw_slot.sv
module cfp_sw_slot
  import cfp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_en,
  input  cmd_t in_cmd,
  input  logic pop,
  output logic busy,
  output cmd_t head
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      head <= '0;
    end else if (pop) begin
      busy <= 1'b0;
    end else if (in_en && !busy) begin
      busy <= 1'b1;
      head <= in_cmd;
    end
  end
endmodule

// File: rtl/cfp_bus_fifo.sv
module cfp_bus_fifo
  import cfp_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  cmd_t din,
  input  logic pop,
  output cmd_t dout,
  output logic full,
  output logic empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  cmd_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cfp_puller.sv
module cfp_puller
  import cfp_pkg::*;
#(
  parameter int RO_DEPTH     = 6,
  parameter int METHOD_LIMIT = 'h800
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_valid,
  input  cmd_t            sw_head,
  input  logic            fifo_empty,
  input  cmd_t            fifo_head,
  input  logic [NSUB-1:0] obj_bound,
  input  logic            ctx_ack,
  output logic            sw_pop,
  output logic            fifo_pop,
  output logic            out_valid,
  output logic            ro_valid,
  output cmd_t            out_cmd,
  output logic [1:0]      out_reason,
  output logic            ctx_req,
  output logic [CH_W-1:0] ctx_chan,
  output logic [CH_W-1:0] active_chan,
  output logic [$clog2(RO_DEPTH+1)-1:0] ro_count,
  output logic            ro_full
);
  localparam int RW = $clog2(RO_DEPTH+1);

  cmd_t       head;
  logic       have, chan_ok, take;
  logic [1:0] reason;

  always_comb begin
    head    = sw_valid ? sw_head : fifo_head;
    have    = sw_valid || !fifo_empty;
    chan_ok = (head.chan == active_chan);
    take    = have && chan_ok && !ctx_req;
    reason  = {(32'(head.method) >= 32'(METHOD_LIMIT)), !obj_bound[head.subch]};
  end

  assign sw_pop   = take && sw_valid;
  assign fifo_pop = take && !sw_valid;
  assign ro_full  = (ro_count == RW'(RO_DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      ro_valid    <= 1'b0;
      out_cmd     <= '0;
      out_reason  <= '0;
      ctx_req     <= 1'b0;
      ctx_chan    <= '0;
      active_chan <= '0;
      ro_count    <= '0;
    end else begin
      out_valid <= 1'b0;
      ro_valid  <= 1'b0;
      if (take) begin
        out_cmd    <= head;
        out_reason <= reason;
        if (reason == 2'b00) begin
          out_valid <= 1'b1;
        end else begin
          ro_valid <= 1'b1;
          if (!ro_full) ro_count <= ro_count + 1'b1;
        end
      end
      if (ctx_req) begin
        if (ctx_ack) begin
          active_chan <= ctx_chan;
          ctx_req     <= 1'b0;
        end
      end else if (have && !chan_ok) begin
        ctx_req  <= 1'b1;
        ctx_chan <= head.chan;
      end
    end
  end
endmodule

// File: rtl/cmd_fifo_puller.sv
module cmd_fifo_puller
  import cfp_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int RO_DEPTH     = 6,
  parameter int METHOD_LIMIT = 'h800
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_wait,
  input  logic            sw_en,
  input  logic [AW-1:0]   sw_addr,
  input  logic [DW-1:0]   sw_data,
  output logic            sw_busy,
  input  logic [NSUB-1:0] obj_bound,
  input  logic            ctx_ack,
  output logic            ctx_req,
  output logic [CH_W-1:0] ctx_chan,
  output logic [CH_W-1:0] active_chan,
  output logic            out_valid,
  output logic            ro_valid,
  output logic [CH_W-1:0] out_chan,
  output logic [SC_W-1:0] out_subch,
  output logic [MT_W-1:0] out_method,
  output logic [DW-1:0]   out_data,
  output logic [1:0]      out_reason,
  output logic [$clog2(RO_DEPTH+1)-1:0] ro_count,
  output logic            ro_full
);
  cmd_t sw_head, fifo_head, out_cmd;
  logic sw_pop, fifo_pop, fifo_empty;
  logic [$clog2(DEPTH+1)-1:0] fifo_cnt;

  cfp_sw_slot u_slot (
    .clk(clk), .rst(rst), .in_en(sw_en), .in_cmd(split_addr(sw_addr, sw_data)),
    .pop(sw_pop), .busy(sw_busy), .head(sw_head)
  );

  cfp_bus_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_en), .din(split_addr(wr_addr, wr_data)),
    .pop(fifo_pop), .dout(fifo_head), .full(wr_wait), .empty(fifo_empty),
    .count(fifo_cnt)
  );

  cfp_puller #(.RO_DEPTH(RO_DEPTH), .METHOD_LIMIT(METHOD_LIMIT)) u_pull (
    .clk(clk), .rst(rst), .sw_valid(sw_busy), .sw_head(sw_head),
    .fifo_empty(fifo_empty), .fifo_head(fifo_head), .obj_bound(obj_bound),
    .ctx_ack(ctx_ack), .sw_pop(sw_pop), .fifo_pop(fifo_pop),
    .out_valid(out_valid), .ro_valid(ro_valid), .out_cmd(out_cmd),
    .out_reason(out_reason), .ctx_req(ctx_req), .ctx_chan(ctx_chan),
    .active_chan(active_chan), .ro_count(ro_count), .ro_full(ro_full)
  );

  assign out_chan   = out_cmd.chan;
  assign out_subch  = out_cmd.subch;
  assign out_method = out_cmd.method;
  assign out_data   = out_cmd.data;
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int DEPTH    = 32,
  parameter int RO_DEPTH = 6
) (
  input logic clk,
  input logic rst,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic wr_wait,
  input logic wr_en,
  input logic out_valid,
  input logic ro_valid,
  input logic [1:0] out_reason,
  input logic ctx_req,
  input logic ctx_ack,
  input logic [2:0] ctx_chan,
  input logic [2:0] active_chan,
  input logic [2:0] out_chan,
  input logic [$clog2(RO_DEPTH+1)-1:0] ro_count
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    32'(fifo_cnt) <= DEPTH);
  a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_wait && wr_en) |=> (32'(fifo_cnt) <= DEPTH));
  a_r6_one_route: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && ro_valid));
  a_r6_active_only: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan == active_chan));
  a_r7_reason_set: assert property (@(posedge clk) disable iff (rst)
    ro_valid |-> (out_reason != 2'b00));
  a_r9_sat: assert property (@(posedge clk) disable iff (rst)
    32'(ro_count) <= RO_DEPTH);
  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    ctx_req |=> !(out_valid || ro_valid));
  a_r10_switch: assert property (@(posedge clk) disable iff (rst)
    (ctx_req && ctx_ack) |=> (!ctx_req && active_chan == $past(ctx_chan)));
  a_r11_no_req: assert property (@(posedge clk) disable iff (rst)
    (!ctx_req) |=> $stable(active_chan));
endmodule

bind cmd_fifo_puller cfp_checker #(.DEPTH(DEPTH), .RO_DEPTH(RO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .fifo_cnt(fifo_cnt), .wr_wait(wr_wait), .wr_en(wr_en),
  .out_valid(out_valid), .ro_valid(ro_valid), .out_reason(out_reason),
  .ctx_req(ctx_req), .ctx_ack(ctx_ack), .ctx_chan(ctx_chan),
  .active_chan(active_chan), .out_chan(out_chan), .ro_count(ro_count)
);

// File: tb/cmd_fifo_puller_tb.sv
module cmd_fifo_puller_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int RO_DEPTH = 6;
  localparam int MLIM = 'h800;
  localparam logic [7:0] BOUND = 8'b1011_0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, sw_en = 0, ctx_ack = 0;
  logic [18:0] wr_addr = '0, sw_addr = '0;
  logic [31:0] wr_data = '0, sw_data = '0;
  logic wr_wait, sw_busy, ctx_req, out_valid, ro_valid, ro_full;
  logic [2:0] ctx_chan, active_chan, out_chan, out_subch, ro_count;
  logic [12:0] out_method;
  logic [31:0] out_data;
  logic [1:0] out_reason;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_fifo_puller #(.DEPTH(DEPTH), .RO_DEPTH(RO_DEPTH), .METHOD_LIMIT(MLIM)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_wait(wr_wait), .sw_en(sw_en), .sw_addr(sw_addr), .sw_data(sw_data),
    .sw_busy(sw_busy), .obj_bound(BOUND), .ctx_ack(ctx_ack), .ctx_req(ctx_req),
    .ctx_chan(ctx_chan), .active_chan(active_chan), .out_valid(out_valid),
    .ro_valid(ro_valid), .out_chan(out_chan), .out_subch(out_subch),
    .out_method(out_method), .out_data(out_data), .out_reason(out_reason),
    .ro_count(ro_count), .ro_full(ro_full)
  );

  int total = 0, bad = 0, n_log = 0, exp_ro = 0;
  logic        lg_exec [256];
  logic [2:0]  lg_chan [256];
  logic [2:0]  lg_sc   [256];
  logic [12:0] lg_mt   [256];
  logic [31:0] lg_data [256];
  logic [1:0]  lg_rsn  [256];

  always @(negedge clk) begin
    if (!rst && (out_valid || ro_valid) && n_log < 256) begin
      lg_exec[n_log] <= out_valid;
      lg_chan[n_log] <= out_chan;
      lg_sc[n_log]   <= out_subch;
      lg_mt[n_log]   <= out_method;
      lg_data[n_log] <= out_data;
      lg_rsn[n_log]  <= out_reason;
      n_log <= n_log + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] ch, input logic [2:0] sc, input logic [12:0] m,
                        input logic [31:0] d);
    wr_en = 1; wr_addr = {ch, sc, m}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sw_wr(input logic [2:0] ch, input logic [2:0] sc, input logic [12:0] m,
                       input logic [31:0] d);
    sw_en = 1; sw_addr = {ch, sc, m}; sw_data = d;
    @(negedge clk);
    sw_en = 0;
  endtask

  task automatic ack();
    ctx_ack = 1;
    @(negedge clk);
    ctx_ack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    logic [12:0] mts [4];
    mts[0] = 13'h0; mts[1] = 13'h7FC; mts[2] = 13'h800; mts[3] = 13'h1FFC;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2: reset state
    chk(active_chan == 0 && !ctx_req && !out_valid && !ro_valid, "R2", active_chan, 0);
    chk(!wr_wait && !sw_busy && ro_count == 0, "R2", {wr_wait, sw_busy, ro_count}, 0);

    // R6: latency, accepted at one edge, visible after the next
    bus_wr(3'd0, 3'd0, 13'h10, 32'hA5A5_0001);
    chk(!out_valid, "R6", out_valid, 0);
    @(negedge clk);
    chk(out_valid && out_data == 32'hA5A5_0001, "R6", out_data, 32'hA5A5_0001);
    idle(2);

    // R1 R7 R8: sweep every subchannel against method offsets around the limit
    base = n_log;
    for (int sc = 0; sc < 8; sc++)
      for (int k = 0; k < 4; k++)
        bus_wr(3'd0, 3'(sc), mts[k], 32'(sc * 16 + k));
    idle(5);
    chk(n_log - base == 32, "R6", n_log - base, 32);
    for (int sc = 0; sc < 8; sc++)
      for (int k = 0; k < 4; k++) begin
        int i;
        logic [1:0] er;
        i = base + sc * 4 + k;
        er = {(32'(mts[k]) >= MLIM), !BOUND[sc]};
        if (er != 0) exp_ro++;
        chk(lg_sc[i] == 3'(sc) && lg_mt[i] == mts[k] && lg_chan[i] == 0, "R1",
            {lg_chan[i], lg_sc[i], lg_mt[i]}, {3'd0, 3'(sc), mts[k]});
        chk(lg_data[i] == 32'(sc * 16 + k), "R1", lg_data[i], sc * 16 + k);
        chk(lg_exec[i] == (er == 0), er[0] ? "R7" : "R8", lg_exec[i], er == 0);
        if (er != 0) chk(lg_rsn[i] == er, er[1] ? "R8" : "R7", lg_rsn[i], er);
      end
    chk(32'(ro_count) == ((exp_ro > RO_DEPTH) ? RO_DEPTH : exp_ro), "R9", ro_count, exp_ro);

    // R10 R3: other channel stalls the puller; fill the FIFO
    base = n_log;
    for (int i = 0; i < DEPTH; i++) bus_wr(3'd1, 3'd0, 13'(i * 4), 32'(100 + i));
    chk(wr_wait, "R3", wr_wait, 1);
    chk(ctx_req && ctx_chan == 1 && active_chan == 0, "R10", {ctx_req, ctx_chan}, 4'h9);
    bus_wr(3'd1, 3'd0, 13'h0, 32'd999);
    idle(3);
    chk(n_log == base, "R10", n_log - base, 0);
    ack();
    chk(!ctx_req && active_chan == 1, "R10", active_chan, 1);
    idle(DEPTH + 4);
    chk(n_log - base == DEPTH, "R3", n_log - base, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(lg_data[base + i] == 32'(100 + i) && lg_chan[base + i] == 1, "R3",
          lg_data[base + i], 100 + i);
    chk(!wr_wait, "R3", wr_wait, 0);

    // R11: stray acknowledge
    ack();
    idle(1);
    chk(active_chan == 1 && !ctx_req, "R11", active_chan, 1);

    // R4 R5: injected entry goes first; second injection while busy dropped
    base = n_log;
    bus_wr(3'd2, 3'd1, 13'h20, 32'd500);
    idle(1);
    chk(ctx_req && ctx_chan == 2, "R10", ctx_chan, 2);
    sw_wr(3'd2, 3'd2, 13'h24, 32'd600);
    chk(sw_busy, "R4", sw_busy, 1);
    sw_wr(3'd2, 3'd2, 13'h28, 32'd601);
    bus_wr(3'd2, 3'd1, 13'h2C, 32'd501);
    ack();
    idle(6);
    chk(n_log - base == 3, "R4", n_log - base, 3);
    chk(lg_data[base] == 600, "R5", lg_data[base], 600);
    chk(lg_data[base + 1] == 500 && lg_data[base + 2] == 501, "R5", lg_data[base + 1], 500);
    chk(!sw_busy, "R4", sw_busy, 0);

    // R9: runout count saturates
    for (int i = 0; i < 8; i++) begin
      bus_wr(3'd2, 3'd3, 13'h0, 32'(700 + i));
      exp_ro++;
    end
    idle(4);
    chk(32'(ro_count) == ((exp_ro > RO_DEPTH) ? RO_DEPTH : exp_ro), "R9", ro_count, RO_DEPTH);
    chk(ro_full == (exp_ro >= RO_DEPTH), "R9", ro_full, 1);
    chk(lg_exec[n_log - 1] == 0 && lg_rsn[n_log - 1] == 2'b01, "R7", lg_rsn[n_log - 1], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule